// File: doc/BRIEF.md
# Speculative Windowed-Carry Adder with One-Cycle Recovery

This block adds two WIDTH-bit operands and a carry-in. It first forms a quick sum in which every carry is built only from the SPAN bit positions just below it, using Ling pseudo-carry terms. That quick sum is right unless a carry must travel across SPAN or more consecutive propagating positions. A detector finds exactly those operand pairs. When the detector fires, the block holds the operands and spends one more cycle on a full-width carry computation. The value it delivers is therefore always exact, and the latency varies with the operands.

Operands enter through a valid/ready handshake. A result comes back as a single-cycle pulse on `out_valid`, together with a flag that tells whether the correction path produced it. The block has no output back-pressure, so the consumer must take each result in the cycle it appears.

Top module: `spec_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `out_valid` is 0, `in_ready` is 1, and `sum`, `cout` and `miss` are all 0.
- R2: Every delivered result satisfies {`cout`,`sum`} = `a` + `b` + `cin`, computed at WIDTH+1 bits.
- R3: If an accepted operand pair is not a miss, `out_valid` is 1 in the cycle after the accepting edge and `miss` is 0.
- R4: An operand pair is a miss exactly when both of the following hold: (a) some SPAN consecutive bit positions s..s+SPAN-1 inside the word all have propagate `a`^`b` = 1, and (b) the true carry into position s is 1, where the carry into position 0 is `cin`. Each delivered result carries `miss` = 1 for a miss and 0 otherwise.
- R5: If an accepted operand pair is a miss, `out_valid` is 0 in the cycle after the accepting edge and 1 in the cycle after that.
- R6: During the correction cycle `in_ready` is 0. Operands offered then are not taken: the delivered result belongs to the earlier pair, and the offered pair is accepted only once `in_ready` returns.
- R7: The window boundary with SPAN=3 behaves as follows:
  - A fed propagate run of length 2 is a hit.
  - Fed runs of length 3 and 4 are misses.
  - A run of length 3 with no carry into it is a hit.
  - A run fed by `cin` at bit 0 is a miss.
  - A run that ends at the most significant bit and drives the carry-out is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Operands are taken on an edge where this and in_valid are both high |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| out_valid | output | 1 | One-cycle pulse marking a delivered result |
| sum | output | WIDTH | Sum bits of the result |
| cout | output | 1 | Carry-out of the result |
| miss | output | 1 | Result came from the correction path |

## Verification
The latency properties assume the environment asserts `in_valid` only with stable, known operands. They also assume nothing consumes a result outside its single pulse. The driver meets both assumptions: it changes inputs only on the falling edge and keeps each pair steady until the edge that takes it. The property tying a hit to an exact quick sum is checked only while `in_valid` is high, because the operand lines carry no meaning at other times.

The stimulus sweeps every 8-bit operand pair, with the carry-in derived from operand bits. Directed pairs then place propagate runs of length SPAN-1, SPAN and SPAN+1 at the bottom, in the middle and at the top of the word. A further directed case offers new operands during a correction cycle to exercise the stall.

// File: rtl/spec_adder_pkg.sv
// Shared types for the speculative adder.
// Assumes nothing beyond the IEEE 1800-2017 enum semantics.
package spec_adder_pkg;

    // Controller phase: taking operands, or finishing an exact correction.
    typedef enum logic {
        PH_RUN = 1'b0,
        PH_FIX = 1'b1
    } add_phase_t;

endpackage

// File: rtl/spec_add_window.sv
// Windowed Ling carry network.
// For each position J it forms the carry into J from bit positions
// max(0, J-SPAN) .. J-1 only. The carry-in takes part only when the window
// reaches bit 0. The Ling form is carry[J] = t[J-1] & (g[J-1] | c*[J-1]),
// where c*[J-1] is the windowed carry into J-1.
// With SPAN >= WIDTH every window reaches bit 0 and the network is exact.
// Assumes gen_i = a & b and tx_i = a | b for the same operand pair.
module spec_add_window #(
    parameter int WIDTH = 8,
    parameter int SPAN  = 3
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] tx_i,
    input  logic             cin_i,
    output logic [WIDTH:0]   carry_o
);

    assign carry_o[0] = cin_i;

    for (genvar J = 1; J <= WIDTH; J++) begin : g_pos
        localparam int LO = (J > SPAN) ? (J - SPAN) : 0;
        logic pseudo;
        logic below;
        logic chain;

        // Purpose: Ling pseudo-carry over the bounded window below position J.
        always_comb begin
            below = 1'b0;
            chain = 1'b1;
            for (int k = J - 2; k >= LO; k--) begin
                below = below | (chain & gen_i[k]);
                chain = chain & tx_i[k];
            end
            if (LO == 0) begin
                below = below | (chain & cin_i);
            end
            pseudo = gen_i[J-1] | below;
        end

        assign carry_o[J] = tx_i[J-1] & pseudo;
    end

endmodule

// File: rtl/spec_add_detect.sv
// Miss detector for the windowed carry network.
// Flags an operand pair when a run of SPAN propagate ones starts at position
// s and a carry enters that run. The carry into s is a generate at s-1, or
// cin when s = 0. A longer run only needs its lowest window checked: the
// carry into the run's start must come from a generate or from cin.
// Assumes prop_i = a ^ b and gen_i = a & b.
module spec_add_detect #(
    parameter int WIDTH = 8,
    parameter int SPAN  = 3
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] gen_i,
    input  logic             cin_i,
    output logic             miss_o
);

    localparam int STARTS = (SPAN <= WIDTH) ? (WIDTH - SPAN + 1) : 0;

    if (STARTS > 0) begin : g_windows
        logic [STARTS-1:0] hit;

        for (genvar S = 0; S < STARTS; S++) begin : g_start
            logic feed;
            if (S == 0) begin : g_low
                assign feed = cin_i;
            end else begin : g_mid
                assign feed = gen_i[S-1];
            end
            assign hit[S] = (&prop_i[S +: SPAN]) & feed;
        end

        assign miss_o = |hit;
    end else begin : g_none
        assign miss_o = 1'b0;
    end

endmodule

// File: rtl/spec_adder.sv
// Variable-latency speculative adder.
// A hit returns the windowed Ling sum one cycle after the operands are
// taken. A miss holds the operands and returns the exact full-width sum one
// cycle later; in_ready stays low during that correction cycle.
// Assumes operands are stable while in_valid is high and that each result
// is consumed during its single out_valid cycle.
module spec_adder
    import spec_adder_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SPAN  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             miss
);

    add_phase_t       phase;
    logic [WIDTH-1:0] hold_a;
    logic [WIDTH-1:0] hold_b;
    logic             hold_c;

    // Live-operand bit terms for the quick path and the detector.
    logic [WIDTH-1:0] live_g;
    logic [WIDTH-1:0] live_t;
    logic [WIDTH-1:0] live_p;
    logic [WIDTH:0]   quick_c;
    logic             spec_miss;

    assign live_g = a & b;
    assign live_t = a | b;
    assign live_p = a ^ b;

    spec_add_window #(.WIDTH(WIDTH), .SPAN(SPAN)) u_quick (
        .gen_i   (live_g),
        .tx_i    (live_t),
        .cin_i   (cin),
        .carry_o (quick_c)
    );

    spec_add_detect #(.WIDTH(WIDTH), .SPAN(SPAN)) u_detect (
        .prop_i  (live_p),
        .gen_i   (live_g),
        .cin_i   (cin),
        .miss_o  (spec_miss)
    );

    // Held-operand bit terms for the exact correction path.
    logic [WIDTH-1:0] hold_g;
    logic [WIDTH-1:0] hold_t;
    logic [WIDTH:0]   exact_c;

    assign hold_g = hold_a & hold_b;
    assign hold_t = hold_a | hold_b;

    spec_add_window #(.WIDTH(WIDTH), .SPAN(WIDTH)) u_exact (
        .gen_i   (hold_g),
        .tx_i    (hold_t),
        .cin_i   (hold_c),
        .carry_o (exact_c)
    );

    assign in_ready = (phase == PH_RUN);

    // Purpose: take operands, issue hit results, and run the correction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_RUN;
            out_valid <= 1'b0;
            sum       <= '0;
            cout      <= 1'b0;
            miss      <= 1'b0;
            hold_a    <= '0;
            hold_b    <= '0;
            hold_c    <= 1'b0;
        end else begin
            case (phase)
                PH_RUN: begin
                    out_valid <= 1'b0;
                    if (in_valid) begin
                        if (spec_miss) begin
                            phase  <= PH_FIX;
                            hold_a <= a;
                            hold_b <= b;
                            hold_c <= cin;
                        end else begin
                            out_valid <= 1'b1;
                            sum       <= live_p ^ quick_c[WIDTH-1:0];
                            cout      <= quick_c[WIDTH];
                            miss      <= 1'b0;
                        end
                    end
                end
                default: begin
                    phase     <= PH_RUN;
                    out_valid <= 1'b1;
                    sum       <= (hold_a ^ hold_b) ^ exact_c[WIDTH-1:0];
                    cout      <= exact_c[WIDTH];
                    miss      <= 1'b1;
                end
            endcase
        end
    end

    // R4: when the detector stays quiet, the windowed sum equals the true sum.
    a_r4_hit_quick_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !spec_miss) |->
            ({quick_c[WIDTH], live_p ^ quick_c[WIDTH-1:0]} ==
             ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})));

    // R3: a hit is delivered on the next cycle with the miss flag clear.
    a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !spec_miss) |=> (out_valid && !miss));

    // R5 and R6: a miss stalls for one cycle with nothing delivered and ready low.
    a_r6_stall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && spec_miss) |=> (!out_valid && !in_ready));

    // R5: the corrected result arrives two cycles after acceptance, flagged.
    a_r5_miss_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && spec_miss) |=> ##1 (out_valid && miss && in_ready));

endmodule

// File: tb/spec_adder_test.sv
`timescale 1ns/1ps
module spec_adder_test;

    localparam int W = 8;
    localparam int K = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         cout;
    logic         miss;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spec_adder #(.WIDTH(W), .SPAN(K)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .a         (a),
        .b         (b),
        .cin       (cin),
        .out_valid (out_valid),
        .sum       (sum),
        .cout      (cout),
        .miss      (miss)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference for the miss condition (R4): a run of K propagate ones at s
    // with an arithmetic carry into position s.
    function automatic logic miss_ref(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic ci);
        logic [W-1:0] pv;
        logic         found;
        pv    = x ^ y;
        found = 1'b0;
        for (int s = 0; s <= W - K; s++) begin
            logic         run;
            logic [W:0]   mask;
            logic [W:0]   part;
            run = 1'b1;
            for (int k = 0; k < K; k++) run = run & pv[s+k];
            mask = ({{W{1'b0}}, 1'b1} << s) - 1'b1;
            part = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {{W{1'b0}}, ci};
            if (run && part[s]) found = 1'b1;
        end
        return found;
    endfunction

    // Offer one pair at a falling edge and check the delivered result.
    task automatic run_op(input logic [W-1:0] ta, input logic [W-1:0] tb,
                          input logic tc, input string tag);
        logic [W:0] exp_full;
        logic       exp_miss;
        exp_full = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tc};
        exp_miss = miss_ref(ta, tb, tc);
        a = ta; b = tb; cin = tc; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (exp_miss) begin
            check(!out_valid && !in_ready, {tag, " R5 stall"},
                  {30'd0, out_valid, in_ready}, 32'd0);
            @(negedge clk);
        end else begin
            check(out_valid === 1'b1, {tag, " R3 hit latency"}, {31'd0, out_valid}, 32'd1);
        end
        check(out_valid === 1'b1, {tag, " R5 valid"}, {31'd0, out_valid}, 32'd1);
        check({cout, sum} === exp_full, {tag, " R2 sum"}, {23'd0, cout, sum},
              {23'd0, exp_full});
        check(miss === exp_miss, {tag, " R4 miss flag"}, {31'd0, miss}, {31'd0, exp_miss});
    endtask

    initial begin
        #1_900_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && in_ready && sum == '0 && !cout && !miss, "R1 reset",
              {22'd0, out_valid, in_ready, sum}, 32'h100);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 directed boundary runs around the window length K = 3.
        run_op(8'b0000_0111, 8'b0000_0001, 1'b0, "R7 run2");
        run_op(8'b0000_1111, 8'b0000_0001, 1'b0, "R7 run3");
        run_op(8'b0001_1111, 8'b0000_0001, 1'b0, "R7 run4");
        run_op(8'b0000_1110, 8'b0000_0000, 1'b0, "R7 unfed");
        run_op(8'b0000_0111, 8'b0000_0000, 1'b1, "R7 cin-fed");
        run_op(8'b1111_0000, 8'b0001_0000, 1'b0, "R7 top");
        run_op(8'hFF, 8'h00, 1'b1, "R7 full");

        // R6: operands offered during the correction cycle are held off.
        a = 8'b0000_1111; b = 8'b0000_0001; cin = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        a = 8'h21; b = 8'h42; cin = 1'b0;
        check(!in_ready && !out_valid, "R6 ready low in fix", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check(out_valid && {cout, sum} == 9'h10 && miss, "R6 earlier pair delivered",
              {23'd0, cout, sum}, 32'h10);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && {cout, sum} == 9'h63 && !miss, "R6 held-off pair taken later",
              {23'd0, cout, sum}, 32'h63);
        @(negedge clk);

        // R2 R3 R4 R5: sweep of all operand pairs, carry-in from operand bits.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                logic [W-1:0] xa;
                logic [W-1:0] xb;
                xa = W'(i);
                xb = W'(j);
                run_op(xa, xb, xa[3] ^ xb[5], "sweep");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule